// File: doc/BRIEF.md
# Deferred-Exception Speculative Load Tracker

This block keeps a poison flag for every general register so that loads can be hoisted above branches without trapping. A hoisted (speculative) load that hits a bad address raises no exception. It marks its destination register as poisoned. A hoisted load with a good address leaves the destination clean. Arithmetic results inherit poison from either source. The fault is reported only when an explicit check operation names a poisoned register. The check then emits a redirect pulse to the recovery address supplied with it, and the fix-up code there re-issues the load.

The pipeline presents at most one event per clock: an event kind, destination and source register indices, a fault flag and a recovery target. The block returns the full poison vector and a registered redirect request. Memory access and the recovery code are outside the block.

Top module: `spec_load_tracker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every bit of `tok_q` is 0 and `redirect_valid` is 0.
- R2: A valid event of kind 3'd1 (speculative load) with `evt_fault` low clears the poison bit of `evt_dst`. The new value is visible after the next rising edge.
- R3: A valid kind 3'd1 event with `evt_fault` high sets the poison bit of `evt_dst` and raises no redirect.
- R4: A valid kind 3'd3 event (arithmetic) sets the poison bit of `evt_dst` to the OR of the poison bits of `evt_src_a` and `evt_src_b`, as they stood before the edge.
- R5: A valid kind 3'd2 event (ordinary write) clears the poison bit of `evt_dst`, whatever the value of `evt_fault`.
- R6: A valid kind 3'd4 event (check of `evt_src_a`) on a poisoned register drives `redirect_valid` high for exactly the one cycle after the edge, with `redirect_target` equal to that event's `evt_target`. Back-to-back poisoned checks give back-to-back pulses.
- R7: A check on a clean register produces no redirect. A check of either kind leaves every poison bit unchanged.
- R8: Register 0 always reads clean (bit 0 of `tok_q` is 0). Writes to it have no effect, and a check of register 0 never redirects.
- R9: While `evt_valid` is low, no poison bit changes and no redirect is raised, whatever the other event inputs are.
- R10: Event kinds 3'd0, 3'd5, 3'd6 and 3'd7 change no poison bit and raise no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_kind | input | 3 | 0 none, 1 speculative load, 2 ordinary write, 3 arithmetic, 4 check, 5-7 none |
| evt_dst | input | IDX_W (5) | Destination register index |
| evt_src_a | input | IDX_W (5) | First source; the register examined by a check |
| evt_src_b | input | IDX_W (5) | Second source for arithmetic |
| evt_fault | input | 1 | Address of a speculative load is invalid |
| evt_target | input | TGT_W (48) | Recovery address carried by a check |
| tok_q | output | NUM_REGS (32) | Poison bit per register |
| redirect_valid | output | 1 | One-cycle recovery request |
| redirect_target | output | TGT_W (48) | Recovery address for the request |

## Verification
The bench aims at the cases where poison must appear, vanish or stay put. A faulting load into register 0 must leave bit 0 clean; a design that stores it would later redirect on a check of register 0. An ordinary write with the fault flag high must still clear the bit; a design that copied the flag would poison a clean register. Arithmetic must read its sources before the write lands, as in a self-referencing op; a design that used the new value would miss a propagation. Checks come back to back and after an idle cycle to show that the pulse lasts one cycle and that a clean check leaves state untouched. Idle cycles and the unused kinds carry live-looking indices and fault flags to catch decoders that act on them.

// File: rtl/stl_pkg.sv
package stl_pkg;

  typedef enum logic [2:0] {
    EVK_NONE  = 3'd0,
    EVK_SPEC  = 3'd1,
    EVK_PLAIN = 3'd2,
    EVK_ALU   = 3'd3,
    EVK_CHECK = 3'd4
  } evt_kind_e;

endpackage

// File: rtl/stl_event_decode.sv
module stl_event_decode
  import stl_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             evt_valid,
  input  logic [2:0]       evt_kind,
  input  logic [IDX_W-1:0] evt_dst,
  input  logic             evt_fault,
  input  logic             src_a_tok,
  input  logic             src_b_tok,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_tok,
  output logic             chk_en,
  output logic             chk_tok
);

  evt_kind_e kind;

  always_comb begin
    kind    = evt_kind_e'(evt_kind);
    wr_en   = 1'b0;
    wr_idx  = evt_dst;
    wr_tok  = 1'b0;
    chk_en  = 1'b0;
    chk_tok = src_a_tok;
    if (evt_valid) begin
      case (kind)
        EVK_SPEC: begin
          wr_en  = 1'b1;
          wr_tok = evt_fault;
        end
        EVK_PLAIN: begin
          wr_en  = 1'b1;
          wr_tok = 1'b0;
        end
        EVK_ALU: begin
          wr_en  = 1'b1;
          wr_tok = src_a_tok | src_b_tok;
        end
        EVK_CHECK: chk_en = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stl_token_file.sv
module stl_token_file #(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_tok,
  input  logic [IDX_W-1:0]    rd_a_idx,
  input  logic [IDX_W-1:0]    rd_b_idx,
  output logic                rd_a_tok,
  output logic                rd_b_tok,
  output logic [NUM_REGS-1:0] tok_q
);

  assign tok_q[0] = 1'b0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_tok
    logic ce;
    logic tok_d;

    always_comb begin
      ce    = wr_en && (wr_idx == IDX_W'(i));
      tok_d = ce ? wr_tok : tok_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tok_q[i] <= 1'b0;
      else if (ce) tok_q[i] <= tok_d;
    end
  end

  assign rd_a_tok = tok_q[rd_a_idx];
  assign rd_b_tok = tok_q[rd_b_idx];

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=> (tok_q[$past(wr_idx)] == $past(wr_tok)));

endmodule

// File: rtl/stl_check_unit.sv
module stl_check_unit #(
  parameter int TGT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             chk_tok,
  input  logic [TGT_W-1:0] chk_target,
  output logic             redirect_valid,
  output logic [TGT_W-1:0] redirect_target
);

  logic hit_d;
  logic redir_q;
  logic [TGT_W-1:0] tgt_q;

  always_comb hit_d = chk_en & chk_tok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redir_q <= 1'b0;
    else        redir_q <= hit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tgt_q <= '0;
    else if (hit_d) tgt_q <= chk_target;
  end

  assign redirect_valid  = redir_q;
  assign redirect_target = tgt_q;

  p_pulse_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && chk_tok) |=> (redirect_valid && redirect_target == $past(chk_target)));

endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
  parameter int NUM_REGS = 32,
  parameter int TGT_W    = 48,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic [2:0]          evt_kind,
  input  logic [IDX_W-1:0]    evt_dst,
  input  logic [IDX_W-1:0]    evt_src_a,
  input  logic [IDX_W-1:0]    evt_src_b,
  input  logic                evt_fault,
  input  logic [TGT_W-1:0]    evt_target,
  output logic [NUM_REGS-1:0] tok_q,
  output logic                redirect_valid,
  output logic [TGT_W-1:0]    redirect_target
);

  logic             src_a_tok;
  logic             src_b_tok;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_tok;
  logic             chk_en;
  logic             chk_tok;

  stl_event_decode #(.NUM_REGS(NUM_REGS)) u_decode (
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .evt_dst   (evt_dst),
    .evt_fault (evt_fault),
    .src_a_tok (src_a_tok),
    .src_b_tok (src_b_tok),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_tok    (wr_tok),
    .chk_en    (chk_en),
    .chk_tok   (chk_tok)
  );

  stl_token_file #(.NUM_REGS(NUM_REGS)) u_tokens (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tok   (wr_tok),
    .rd_a_idx (evt_src_a),
    .rd_b_idx (evt_src_b),
    .rd_a_tok (src_a_tok),
    .rd_b_tok (src_b_tok),
    .tok_q    (tok_q)
  );

  stl_check_unit #(.TGT_W(TGT_W)) u_check (
    .clk             (clk),
    .rst_n           (rst_n),
    .chk_en          (chk_en),
    .chk_tok         (chk_tok),
    .chk_target      (evt_target),
    .redirect_valid  (redirect_valid),
    .redirect_target (redirect_target)
  );

  p_fault_defers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd1 && evt_fault && evt_dst != '0)
      |=> (tok_q[$past(evt_dst)] && !redirect_valid));

  p_spec_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd1 && !evt_fault) |=> !tok_q[$past(evt_dst)]);

  p_plain_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd2) |=> !tok_q[$past(evt_dst)]);

  p_check_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd4) |=> $stable(tok_q));

  p_redir_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(evt_valid && evt_kind == 3'd4 && tok_q[evt_src_a]));

  p_zero_check_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd4 && evt_src_a == '0) |=> !redirect_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> ($stable(tok_q) && !redirect_valid));

  p_unused_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_kind == 3'd0 || evt_kind > 3'd4)) |=> ($stable(tok_q) && !redirect_valid));

endmodule

// File: tb/spec_load_tracker_bench.sv
module spec_load_tracker_bench;
  localparam int NUM_REGS = 32;
  localparam int TGT_W    = 48;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic                clk = 1'b0;
  logic                rst_n;
  logic                evt_valid;
  logic [2:0]          evt_kind;
  logic [IDX_W-1:0]    evt_dst, evt_src_a, evt_src_b;
  logic                evt_fault;
  logic [TGT_W-1:0]    evt_target;
  logic [NUM_REGS-1:0] tok_q;
  logic                redirect_valid;
  logic [TGT_W-1:0]    redirect_target;

  int errors = 0;
  int checks = 0;
  logic [NUM_REGS-1:0] m_tok;

  always #10 clk = ~clk;

  spec_load_tracker #(.NUM_REGS(NUM_REGS), .TGT_W(TGT_W)) u_spec_load_tracker (.*);

  function automatic string req_of(input logic v, input logic [2:0] k, input logic f);
    if (!v) return "R9";
    case (k)
      3'd1: return f ? "R3" : "R2";
      3'd2: return "R5";
      3'd3: return "R4";
      3'd4: return "R6/R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [NUM_REGS-1:0] next_tok(input logic [NUM_REGS-1:0] t,
      input logic v, input logic [2:0] k, input logic [IDX_W-1:0] d, a, b, input logic f);
    logic [NUM_REGS-1:0] n = t;
    if (v) begin
      case (k)
        3'd1: n[d] = f;
        3'd2: n[d] = 1'b0;
        3'd3: n[d] = t[a] | t[b];
        default: ;
      endcase
    end
    n[0] = 1'b0;
    return n;
  endfunction

  task automatic check_vec(input logic [NUM_REGS-1:0] act, exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s tokens actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input logic act, exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s redirect actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_tgt(input logic [TGT_W-1:0] act, exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s target actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge: drive, let one rising edge pass, sample at the next falling edge.
  task automatic step(input logic v, input logic [2:0] k, input logic [IDX_W-1:0] d, a, b,
                      input logic f, input logic [TGT_W-1:0] tgt);
    logic exp_r;
    string req;
    evt_valid = v; evt_kind = k; evt_dst = d; evt_src_a = a; evt_src_b = b;
    evt_fault = f; evt_target = tgt;
    exp_r = v && (k == 3'd4) && m_tok[a];
    req   = req_of(v, k, f);
    if (v && k == 3'd4 && a == '0) req = "R8";
    else if (v && k inside {3'd1, 3'd2, 3'd3} && d == '0) req = "R8";
    m_tok = next_tok(m_tok, v, k, d, a, b, f);
    @(posedge clk);
    @(negedge clk);
    check_vec(tok_q, m_tok, req);
    check_bit(redirect_valid, exp_r, req);
    if (exp_r) check_tgt(redirect_target, tgt, "R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7919));
    rst_n = 1'b0; evt_valid = 1'b0; evt_kind = 3'd0; evt_dst = '0; evt_src_a = '0;
    evt_src_b = '0; evt_fault = 1'b0; evt_target = '0;
    m_tok = '0;
    repeat (3) @(negedge clk);
    check_vec(tok_q, '0, "R1");
    check_bit(redirect_valid, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_vec(tok_q, '0, "R1");
    check_bit(redirect_valid, 1'b0, "R1");

    // Directed corner cases
    step(1, 3'd1, 5'd3, 5'd0, 5'd0, 1, 48'h1);        // R3 fault poisons r3
    step(1, 3'd1, 5'd0, 5'd0, 5'd0, 1, 48'h2);        // R8 fault into r0 ignored
    step(1, 3'd4, 5'd0, 5'd0, 5'd0, 0, 48'h3);        // R8 check r0 quiet
    step(1, 3'd3, 5'd5, 5'd3, 5'd0, 0, 48'h4);        // R4 propagate r3 -> r5
    step(1, 3'd3, 5'd5, 5'd5, 5'd6, 0, 48'h5);        // R4 self-reference keeps poison
    step(1, 3'd4, 5'd0, 5'd5, 5'd0, 0, 48'hABCD_1234_5678); // R6 redirect
    step(1, 3'd4, 5'd0, 5'd3, 5'd0, 0, 48'h0000_0000_BEEF); // R6 back-to-back
    step(1, 3'd4, 5'd0, 5'd6, 5'd0, 0, 48'hFFFF);     // R7 clean check
    step(0, 3'd1, 5'd6, 5'd3, 5'd3, 1, 48'h7);        // R9 idle with live fields
    step(1, 3'd2, 5'd3, 5'd0, 5'd0, 1, 48'h8);        // R5 plain write with fault flag
    step(1, 3'd6, 5'd7, 5'd5, 5'd5, 1, 48'h9);        // R10 unused kind
    step(1, 3'd0, 5'd7, 5'd5, 5'd5, 1, 48'hA);        // R10 none kind
    step(1, 3'd1, 5'd5, 5'd0, 5'd0, 0, 48'hB);        // R2 clean load clears r5
    step(1, 3'd4, 5'd0, 5'd5, 5'd0, 0, 48'hC);        // R7 now clean

    // Random mix, indices biased toward a small set to build poison chains
    for (int n = 0; n < 4000; n++) begin
      logic [IDX_W-1:0] d, a, b;
      logic [2:0] k;
      logic v;
      d = ($urandom_range(0, 3) == 0) ? IDX_W'($urandom_range(0, NUM_REGS-1)) : IDX_W'($urandom_range(0, 7));
      a = IDX_W'($urandom_range(0, 7));
      b = IDX_W'($urandom_range(0, 7));
      k = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 0) k = 3'($urandom_range(1, 4));
      v = ($urandom_range(0, 7) != 0);
      step(v, k, d, a, b, 1'($urandom_range(0, 1)), {16'($urandom), 32'($urandom)});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule